// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

This block gathers interrupt requests from three kinds of source and hands them to a small cluster of CPUs (four by default). The sources are software-raised inter-processor requests, two per-CPU private lines (a timer and a watchdog), and a set of shared hardware lines. Each interrupt number has an enable bit and a priority. Each shared line also has a set of target CPUs. The block keeps the state of every interrupt separately for each CPU. For each CPU it picks the most urgent eligible request and raises that CPU's request output.

A CPU takes an interrupt by pulsing its acknowledge input. One cycle later the block returns the interrupt number it granted. The CPU finishes the interrupt by pulsing its end-of-interrupt input together with the number. Configuration writes and software-raised requests come in through a simple write port.

Interrupt number map, which every requirement below depends on:
- 0 to 15: software-raised, private to each CPU.
- 29: private timer of each CPU.
- 30: private watchdog of each CPU.
- 32 and up: one number per shared line, so line k is number 32+k.
- Number 1023 is the spurious response.

A lower priority value is more urgent.

Top module: `mp_irq_distributor`

## Requirements
- R1: After reset every interrupt is Inactive on every CPU, no `irq_o` bit is high, and an acknowledge returns 1023.
- R2: An interrupt whose enable bit is 0 never raises `irq_o` and is never granted, even while its source is asserted.
- R3: Among the Pending, enabled interrupts of a CPU, the one with the lowest priority value is granted; on equal priority the lowest interrupt number wins.
- R4: An acknowledge while `irq_o` is high returns the selected number on `ack_id_o` with `ack_valid_o` one cycle later. That interrupt becomes Active on that CPU only.
- R5: An acknowledge while `irq_o` is low returns 1023 with `ack_valid_o` one cycle later and changes no state.
- R6: While a CPU has Active interrupts, a Pending interrupt is forwarded only if its priority value is strictly below the smallest priority value among the Active ones.
- R7: End-of-interrupt for an Active number moves it to Pending if its line is still asserted for that CPU, otherwise to Inactive. End-of-interrupt for a number that is not Active on that CPU, or that is 40 or above, has no effect.
- R8: Shared line k sets number 32+k Pending on each CPU whose bit is set in that number's 4-bit target mask (bit c = CPU c). Each CPU then moves through the states on its own.
- R9: A software request with `sgi_mode` 0 targets the CPUs in `sgi_list`. Mode 1 targets all CPUs except `sgi_src`. Mode 2 targets `sgi_src` only. Mode 3 targets no CPU.
- R10: Timer line c raises number 29, and watchdog line c raises number 30, on CPU c only.
- R11: A request for a number that is already Pending or Active on a CPU is dropped on that CPU and is not queued.
- R12: A configuration write sets the enable bit and priority of the addressed number. Targets are stored only for numbers 32 and up. Writes to numbers above the highest implemented one are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 6 | Interrupt number written |
| cfg_en | input | 1 | Enable bit value |
| cfg_prio | input | 4 | Priority value (lower is more urgent) |
| cfg_tgt | input | 4 | Target CPU mask for shared numbers |
| sgi_valid | input | 1 | Software request strobe |
| sgi_src | input | 2 | Requesting CPU |
| sgi_id | input | 4 | Software interrupt number 0..15 |
| sgi_mode | input | 2 | 0 list, 1 all but requester, 2 requester only, 3 none |
| sgi_list | input | 4 | Target CPU mask for mode 0 |
| timer_i | input | 4 | Per-CPU private timer lines |
| wdog_i | input | 4 | Per-CPU private watchdog lines |
| spi_i | input | 8 | Shared hardware lines (level) |
| ack_i | input | 4 | Per-CPU acknowledge pulse |
| eoi_i | input | 4 | Per-CPU end-of-interrupt pulse |
| eoi_id_i | input | 40 | Per-CPU end-of-interrupt number, 10 bits per CPU |
| irq_o | output | 4 | Per-CPU interrupt request |
| ack_valid_o | output | 4 | Per-CPU acknowledge response valid |
| ack_id_o | output | 40 | Per-CPU granted number, 10 bits per CPU |

## Verification
The hardest situation to reach from the ports is a CPU that holds a stack of Active interrupts while lower- and equal-priority ones wait Pending. On top of that, a level line may still be high when its end-of-interrupt arrives. The directed part builds this stack on purpose. It acknowledges a shared line, raises an equal-priority rival and then a more urgent one, and ends the urgent one while its line is still held. The reference model then follows a long random phase. In that phase, end-of-interrupt numbers are drawn from what each CPU was last granted, so that nested completion happens often rather than by chance.

// File: rtl/mp_irq_pkg.sv
package mp_irq_pkg;
  localparam int ID_W        = 10;
  localparam int SPURIOUS    = 1023;
  localparam int NUM_SGI     = 16;
  localparam int TIMER_ID    = 29;
  localparam int WDOG_ID     = 30;
  localparam int SHARED_BASE = 32;

  localparam logic [1:0] SGI_LIST   = 2'd0;
  localparam logic [1:0] SGI_OTHERS = 2'd1;
  localparam logic [1:0] SGI_SELF   = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2
  } irq_st_e;
endpackage

// File: rtl/mp_irq_cfg.sv
module mp_irq_cfg
  import mp_irq_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int NSHARED = 8,
  parameter int PRIO_W  = 4,
  localparam int NID    = SHARED_BASE + NSHARED,
  localparam int IDX_W  = $clog2(NID)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [IDX_W-1:0]                  cfg_idx,
  input  logic                              cfg_en,
  input  logic [PRIO_W-1:0]                 cfg_prio,
  input  logic [NCPU-1:0]                   cfg_tgt,
  output logic [NID-1:0]                    en_o,
  output logic [NID-1:0][PRIO_W-1:0]        prio_o,
  output logic [NSHARED-1:0][NCPU-1:0]      tgt_o
);
  logic idx_ok;
  logic tgt_ok;

  assign idx_ok = cfg_we && (int'(cfg_idx) < NID);
  assign tgt_ok = idx_ok && (int'(cfg_idx) >= SHARED_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o   <= '0;
      prio_o <= '0;
    end else if (idx_ok) begin
      en_o[cfg_idx]   <= cfg_en;
      prio_o[cfg_idx] <= cfg_prio;
    end
  end

  genvar k;
  generate
    for (k = 0; k < NSHARED; k++) begin : g_tgt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tgt_o[k] <= '0;
        end else if (tgt_ok && (int'(cfg_idx) == SHARED_BASE + k)) begin
          tgt_o[k] <= cfg_tgt;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mp_irq_route.sv
module mp_irq_route
  import mp_irq_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int NSHARED = 8,
  localparam int NID    = SHARED_BASE + NSHARED,
  localparam int CPU_W  = $clog2(NCPU)
) (
  input  logic                         sgi_valid,
  input  logic [CPU_W-1:0]             sgi_src,
  input  logic [3:0]                   sgi_id,
  input  logic [1:0]                   sgi_mode,
  input  logic [NCPU-1:0]              sgi_list,
  input  logic [NCPU-1:0]              timer_i,
  input  logic [NCPU-1:0]              wdog_i,
  input  logic [NSHARED-1:0]           spi_i,
  input  logic [NSHARED-1:0][NCPU-1:0] tgt_i,
  output logic [NCPU-1:0][NID-1:0]     set_o,
  output logic [NCPU-1:0][NID-1:0]     lvl_o
);
  logic [NCPU-1:0] src_hot;
  logic [NCPU-1:0] sgi_mask;

  assign src_hot = NCPU'(1) << sgi_src;

  always_comb begin
    case (sgi_mode)
      SGI_LIST:   sgi_mask = sgi_list;
      SGI_OTHERS: sgi_mask = ~src_hot;
      SGI_SELF:   sgi_mask = src_hot;
      default:    sgi_mask = '0;
    endcase
  end

  genvar c;
  generate
    for (c = 0; c < NCPU; c++) begin : g_cpu
      always_comb begin
        lvl_o[c] = '0;
        lvl_o[c][TIMER_ID] = timer_i[c];
        lvl_o[c][WDOG_ID]  = wdog_i[c];
        for (int k = 0; k < NSHARED; k++) begin
          lvl_o[c][SHARED_BASE + k] = spi_i[k] & tgt_i[k][c];
        end
        set_o[c] = lvl_o[c];
        if (sgi_valid && sgi_mask[c]) begin
          set_o[c][sgi_id] = 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mp_irq_cpu.sv
module mp_irq_cpu
  import mp_irq_pkg::*;
#(
  parameter int NSHARED = 8,
  parameter int PRIO_W  = 4,
  localparam int NID    = SHARED_BASE + NSHARED,
  localparam int IDX_W  = $clog2(NID)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NID-1:0]             set_i,
  input  logic [NID-1:0]             lvl_i,
  input  logic [NID-1:0]             en_i,
  input  logic [NID-1:0][PRIO_W-1:0] prio_i,
  input  logic                       ack_i,
  input  logic                       eoi_i,
  input  logic [ID_W-1:0]            eoi_id_i,
  output logic                       irq_o,
  output logic                       ack_valid_o,
  output logic [ID_W-1:0]            ack_id_o
);
  irq_st_e          st_q [NID];
  irq_st_e          st_d [NID];
  logic [PRIO_W:0]  run_prio;
  logic [PRIO_W:0]  best_prio;
  logic [IDX_W-1:0] sel_idx;
  logic             found;
  logic             ack_take;
  logic             eoi_in;
  logic [IDX_W-1:0] eoi_idx;
  logic             eoi_hit;
  logic             ack_valid_q;
  logic [ID_W-1:0]  ack_id_q;

  // running priority, then candidate search (ascending scan keeps lowest ID on ties)
  always_comb begin
    run_prio = {1'b1, {PRIO_W{1'b0}}};
    for (int i = 0; i < NID; i++) begin
      if (st_q[i] == ST_ACT && {1'b0, prio_i[i]} < run_prio) begin
        run_prio = {1'b0, prio_i[i]};
      end
    end
    best_prio = {1'b1, {PRIO_W{1'b0}}};
    sel_idx   = '0;
    found     = 1'b0;
    for (int i = 0; i < NID; i++) begin
      if (st_q[i] == ST_PEND && en_i[i] &&
          {1'b0, prio_i[i]} < run_prio && {1'b0, prio_i[i]} < best_prio) begin
        best_prio = {1'b0, prio_i[i]};
        sel_idx   = IDX_W'(i);
        found     = 1'b1;
      end
    end
  end

  assign irq_o    = found;
  assign ack_take = ack_i && found;
  assign eoi_in   = (int'(eoi_id_i) < NID);
  assign eoi_idx  = eoi_id_i[IDX_W-1:0];
  assign eoi_hit  = eoi_i && eoi_in && (st_q[eoi_idx] == ST_ACT);

  always_comb begin
    for (int i = 0; i < NID; i++) begin
      st_d[i] = st_q[i];
      case (st_q[i])
        ST_IDLE: if (set_i[i]) st_d[i] = ST_PEND;
        ST_PEND: if (ack_take && sel_idx == IDX_W'(i)) st_d[i] = ST_ACT;
        ST_ACT:  if (eoi_hit && eoi_idx == IDX_W'(i))
                   st_d[i] = lvl_i[i] ? ST_PEND : ST_IDLE;
        default: st_d[i] = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NID; i++) st_q[i] <= ST_IDLE;
    end else begin
      for (int i = 0; i < NID; i++) st_q[i] <= st_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid_q <= 1'b0;
      ack_id_q    <= ID_W'(SPURIOUS);
    end else begin
      ack_valid_q <= ack_i;
      if (ack_i) begin
        ack_id_q <= found ? ID_W'(sel_idx) : ID_W'(SPURIOUS);
      end
    end
  end

  assign ack_valid_o = ack_valid_q;
  assign ack_id_o    = ack_id_q;

  // R5: nothing eligible gives the spurious number
  assert_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o) |=> (ack_valid_o && ack_id_o == ID_W'(SPURIOUS)));

  // R4: granted number is Active right after the grant
  assert_grant_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> (ack_valid_o && st_q[ack_id_o[IDX_W-1:0]] == ST_ACT));

  // R2: a request is only presented for an enabled number
  assert_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en_i[sel_idx]);

  // R6: presented request beats the running priority strictly
  assert_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ({1'b0, prio_i[sel_idx]} < run_prio));

  // R7: a completed number leaves Active
  assert_eoi_leave_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |=> (st_q[$past(eoi_idx)] != ST_ACT));
endmodule

// File: rtl/mp_irq_distributor.sv
module mp_irq_distributor
  import mp_irq_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int NSHARED = 8,
  parameter int PRIO_W  = 4,
  localparam int NID    = SHARED_BASE + NSHARED,
  localparam int IDX_W  = $clog2(NID),
  localparam int CPU_W  = $clog2(NCPU)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic                   cfg_en,
  input  logic [PRIO_W-1:0]      cfg_prio,
  input  logic [NCPU-1:0]        cfg_tgt,
  input  logic                   sgi_valid,
  input  logic [CPU_W-1:0]       sgi_src,
  input  logic [3:0]             sgi_id,
  input  logic [1:0]             sgi_mode,
  input  logic [NCPU-1:0]        sgi_list,
  input  logic [NCPU-1:0]        timer_i,
  input  logic [NCPU-1:0]        wdog_i,
  input  logic [NSHARED-1:0]     spi_i,
  input  logic [NCPU-1:0]        ack_i,
  input  logic [NCPU-1:0]        eoi_i,
  input  logic [NCPU*ID_W-1:0]   eoi_id_i,
  output logic [NCPU-1:0]        irq_o,
  output logic [NCPU-1:0]        ack_valid_o,
  output logic [NCPU*ID_W-1:0]   ack_id_o
);
  logic [NID-1:0]                en;
  logic [NID-1:0][PRIO_W-1:0]    prio;
  logic [NSHARED-1:0][NCPU-1:0]  tgt;
  logic [NCPU-1:0][NID-1:0]      set_v;
  logic [NCPU-1:0][NID-1:0]      lvl_v;

  mp_irq_cfg #(.NCPU(NCPU), .NSHARED(NSHARED), .PRIO_W(PRIO_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_prio(cfg_prio), .cfg_tgt(cfg_tgt),
    .en_o(en), .prio_o(prio), .tgt_o(tgt)
  );

  mp_irq_route #(.NCPU(NCPU), .NSHARED(NSHARED)) u_route (
    .sgi_valid(sgi_valid), .sgi_src(sgi_src), .sgi_id(sgi_id),
    .sgi_mode(sgi_mode), .sgi_list(sgi_list), .timer_i(timer_i),
    .wdog_i(wdog_i), .spi_i(spi_i), .tgt_i(tgt),
    .set_o(set_v), .lvl_o(lvl_v)
  );

  genvar c;
  generate
    for (c = 0; c < NCPU; c++) begin : g_cpu
      mp_irq_cpu #(.NSHARED(NSHARED), .PRIO_W(PRIO_W)) u_cpu (
        .clk(clk), .rst_n(rst_n),
        .set_i(set_v[c]), .lvl_i(lvl_v[c]), .en_i(en), .prio_i(prio),
        .ack_i(ack_i[c]), .eoi_i(eoi_i[c]),
        .eoi_id_i(eoi_id_i[c*ID_W +: ID_W]),
        .irq_o(irq_o[c]), .ack_valid_o(ack_valid_o[c]),
        .ack_id_o(ack_id_o[c*ID_W +: ID_W])
      );
    end
  endgenerate
endmodule

// File: tb/tb_mp_irq_distributor.sv
module tb_mp_irq_distributor;
  localparam int NCPU = 4, NSH = 8, NID = 40, IW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, sgi_valid = 0;
  logic [5:0] cfg_idx = 0;
  logic [3:0] cfg_prio = 0, cfg_tgt = 0, sgi_id = 0, sgi_list = 0;
  logic [1:0] sgi_src = 0, sgi_mode = 0;
  logic [NCPU-1:0] timer_i = 0, wdog_i = 0, ack_i = 0, eoi_i = 0;
  logic [NSH-1:0] spi_i = 0;
  logic [NCPU*IW-1:0] eoi_id_i = 0;
  logic [NCPU-1:0] irq_o, ack_valid_o;
  logic [NCPU*IW-1:0] ack_id_o;

  mp_irq_distributor dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_prio(cfg_prio), .cfg_tgt(cfg_tgt), .sgi_valid(sgi_valid), .sgi_src(sgi_src),
    .sgi_id(sgi_id), .sgi_mode(sgi_mode), .sgi_list(sgi_list), .timer_i(timer_i),
    .wdog_i(wdog_i), .spi_i(spi_i), .ack_i(ack_i), .eoi_i(eoi_i), .eoi_id_i(eoi_id_i),
    .irq_o(irq_o), .ack_valid_o(ack_valid_o), .ack_id_o(ack_id_o)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit checking = 0;

  // reference model
  int mst[NCPU][NID];
  bit men[NID];
  int mpr[NID];
  bit mtg[NSH][NCPU];
  bit exp_av[NCPU];
  int exp_id[NCPU];
  int last_grant[NCPU];

  function automatic int msel(int c);
    int run = 16, best = 16, s = -1;
    for (int i = 0; i < NID; i++) if (mst[c][i] == 2 && mpr[i] < run) run = mpr[i];
    for (int i = 0; i < NID; i++)
      if (mst[c][i] == 1 && men[i] && mpr[i] < run && mpr[i] < best) begin
        best = mpr[i]; s = i;
      end
    return s;
  endfunction

  function automatic bit mlvl(int c, int id);
    if (id == 29) return timer_i[c];
    if (id == 30) return wdog_i[c];
    if (id >= 32) return spi_i[id-32] && mtg[id-32][c];
    return 0;
  endfunction

  function automatic bit msgi(int c, int id);
    if (!sgi_valid || id != int'(sgi_id)) return 0;
    case (sgi_mode)
      2'd0: return sgi_list[c];
      2'd1: return c != int'(sgi_src);
      2'd2: return c == int'(sgi_src);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++) begin
        exp_av[c] = 0; exp_id[c] = 1023; last_grant[c] = 1023;
        for (int i = 0; i < NID; i++) mst[c][i] = 0;
      end
      for (int i = 0; i < NID; i++) begin men[i] = 0; mpr[i] = 0; end
      for (int k = 0; k < NSH; k++) for (int c = 0; c < NCPU; c++) mtg[k][c] = 0;
    end else begin
      int s[NCPU];
      int ns[NCPU][NID];
      for (int c = 0; c < NCPU; c++) s[c] = msel(c);
      for (int c = 0; c < NCPU; c++) begin
        exp_av[c] = ack_i[c];
        if (ack_i[c]) begin
          exp_id[c] = (s[c] >= 0) ? s[c] : 1023;
          last_grant[c] = exp_id[c];
        end
        for (int i = 0; i < NID; i++) begin
          ns[c][i] = mst[c][i];
          if (mst[c][i] == 0 && (mlvl(c, i) || msgi(c, i))) ns[c][i] = 1;
          if (mst[c][i] == 1 && ack_i[c] && s[c] == i) ns[c][i] = 2;
          if (mst[c][i] == 2 && eoi_i[c] && int'(eoi_id_i[c*IW +: IW]) == i)
            ns[c][i] = mlvl(c, i) ? 1 : 0;
        end
      end
      mst = ns;
      if (cfg_we && int'(cfg_idx) < NID) begin
        men[cfg_idx] = cfg_en;
        mpr[cfg_idx] = int'(cfg_prio);
        if (cfg_idx >= 32) for (int c = 0; c < NCPU; c++) mtg[cfg_idx-32][c] = cfg_tgt[c];
      end
    end
  end

  task automatic chk(bit ok, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      for (int c = 0; c < NCPU; c++) begin
        chk(irq_o[c] == (msel(c) >= 0), $sformatf("irq cpu%0d", c), irq_o[c], msel(c) >= 0);
        chk(ack_valid_o[c] == exp_av[c], $sformatf("ack_valid cpu%0d", c), ack_valid_o[c], exp_av[c]);
        if (exp_av[c])
          chk(int'(ack_id_o[c*IW +: IW]) == exp_id[c], $sformatf("ack_id cpu%0d", c),
              ack_id_o[c*IW +: IW], exp_id[c]);
      end
    end
  end

  task automatic cfg(int id, bit en, int pr, logic [3:0] tg);
    cfg_we = 1; cfg_idx = 6'(id); cfg_en = en; cfg_prio = 4'(pr); cfg_tgt = tg;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic do_ack(int c, int expv);
    ack_i[c] = 1;
    @(negedge clk); ack_i[c] = 0;
    chk(int'(ack_id_o[c*IW +: IW]) == expv, $sformatf("directed ack cpu%0d", c),
        ack_id_o[c*IW +: IW], expv);
  endtask

  task automatic do_eoi(int c, int id);
    eoi_i[c] = 1; eoi_id_i[c*IW +: IW] = IW'(id);
    @(negedge clk); eoi_i[c] = 0;
  endtask

  task automatic do_sgi(int src, int id, int mode, logic [3:0] lst);
    sgi_valid = 1; sgi_src = 2'(src); sgi_id = 4'(id); sgi_mode = 2'(mode); sgi_list = lst;
    @(negedge clk); sgi_valid = 0;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitn(2);
    checking = 1;
    waitn(2);
    rst_n = 1;
    waitn(1);
    cur_req = "R1";
    chk(irq_o == 4'b0000, "reset irq", irq_o, 0);
    do_ack(0, 1023);
    cur_req = "R12";
    cfg(32, 1, 5, 4'b0011);
    cfg(33, 1, 5, 4'b0010);
    cfg(35, 0, 0, 4'b1111);
    cfg(63, 1, 0, 4'b1111);
    cur_req = "R2";
    spi_i[3] = 1;
    waitn(3);
    chk(irq_o == 4'b0000, "masked line", irq_o, 0);
    do_ack(2, 1023);
    cur_req = "R8";
    spi_i[0] = 1;
    waitn(2);
    chk(irq_o == 4'b0011, "shared targets", irq_o, 3);
    cur_req = "R3";
    spi_i[1] = 1;
    waitn(2);
    do_ack(1, 32);
    cur_req = "R6";
    waitn(1);
    chk(irq_o[1] == 1'b0, "equal prio blocked", irq_o[1], 0);
    cfg(34, 1, 2, 4'b0010);
    spi_i[2] = 1;
    waitn(2);
    chk(irq_o[1] == 1'b1, "higher prio preempts", irq_o[1], 1);
    do_ack(1, 34);
    cur_req = "R7";
    do_eoi(1, 34);
    waitn(1);
    chk(irq_o[1] == 1'b1, "eoi repends held line", irq_o[1], 1);
    do_ack(1, 34);
    spi_i[2] = 0;
    do_eoi(1, 34);
    do_eoi(1, 7);
    do_eoi(1, 600);
    waitn(1);
    chk(irq_o[1] == 1'b0, "ignored eoi", irq_o[1], 0);
    cur_req = "R9";
    cfg(5, 1, 3, 4'b0000);
    cfg(6, 1, 1, 4'b0000);
    cfg(7, 1, 0, 4'b0000);
    do_sgi(0, 5, 0, 4'b0100);
    do_sgi(1, 5, 1, 4'b0000);
    do_sgi(3, 6, 2, 4'b0000);
    do_sgi(0, 7, 3, 4'b1111);
    waitn(1);
    do_ack(3, 6);
    do_ack(3, 1023);
    cur_req = "R10";
    cfg(29, 1, 0, 4'b0000);
    timer_i[3] = 1;
    waitn(2);
    chk(irq_o[3] == 1'b1, "timer on own cpu", irq_o[3], 1);
    do_ack(3, 29);
    timer_i[3] = 0;
    cur_req = "R11";
    do_sgi(3, 6, 2, 4'b0000);
    do_eoi(3, 29);
    do_eoi(3, 6);
    waitn(1);
    do_ack(3, 5);
    do_ack(3, 1023);
    cur_req = "R3";
    for (int n = 0; n < 4000; n++) begin
      cfg_we = ($urandom_range(0, 7) == 0);
      cfg_idx = 6'($urandom); cfg_en = ($urandom_range(0, 3) != 0);
      cfg_prio = 4'($urandom); cfg_tgt = 4'($urandom);
      sgi_valid = ($urandom_range(0, 5) == 0);
      sgi_src = 2'($urandom); sgi_id = 4'($urandom);
      sgi_mode = 2'($urandom); sgi_list = 4'($urandom);
      if ($urandom_range(0, 9) == 0) timer_i = 4'($urandom);
      if ($urandom_range(0, 9) == 0) wdog_i = 4'($urandom);
      if ($urandom_range(0, 5) == 0) spi_i = 8'($urandom);
      ack_i = 4'($urandom) & 4'($urandom);
      eoi_i = 4'($urandom) & 4'($urandom);
      for (int c = 0; c < NCPU; c++)
        eoi_id_i[c*IW +: IW] = ($urandom_range(0, 3) != 0) ? IW'(last_grant[c])
                                                           : IW'($urandom_range(0, 45));
      @(negedge clk);
    end
    cfg_we = 0; sgi_valid = 0; ack_i = 0; eoi_i = 0;
    waitn(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule